// File: doc/BRIEF.md
# Core Bus Clock Enable Generator

This block runs on the main PLL clock and turns one configuration word into three clock-enable strobes: one for the processor, one for the system bus and one for the peripheral bus. Each strobe is a single-cycle pulse, so downstream logic stays on the one fast clock and only acts on cycles where its enable is high. The processor and bus rates each come from a fixed table selected by a three-bit code. The peripheral rate divides the bus strobe stream further, so peripheral pulses always fall on bus pulses.

A second, independent divider runs on the USB PLL clock. It produces the USB host clock enable from a four-bit field of a second configuration word. Each side also reports whether its PLL is bypassed. Frequency synthesis itself happens elsewhere. Divisor changes in the core domain are deferred to a cycle where all three core strobes fire together, so no strobe period is ever cut short.

Top module: `bus_clk_en_gen`

## Requirements
- R1: The processor strobe `fclk_en` has period 1, 2, 4, 8 or 16 cycles for code 0, 1, 2, 3 or 4 in `cfg_core[27:25]`. Codes 5, 6 and 7 select a period of 1.
- R2: The bus strobe `hclk_en` has period 1, 2, 4, 5, 6, 8, 16 or 32 cycles for code 0 through 7 in `cfg_core[22:20]`.
- R3: The peripheral strobe `pclk_en` fires on every 1st, 2nd, 4th or 8th bus strobe for code 0 through 3 in `cfg_core[19:18]`. It is never high in a cycle where `hclk_en` is low.
- R4: The USB strobe `usb_en` has a period of `cfg_usb[31:28]` + 1 cycles of `usb_clk`.
- R5: Each strobe with a period N greater than 1 is high for exactly one cycle in every N. With a period of 1 the strobe stays high.
- R6: A new `cfg_core` value is taken only at the edge that ends a cycle in which `fclk_en`, `hclk_en` and `pclk_en` are all high. It applies from the next cycle, with every count starting afresh. Changes to `cfg_core` at any other time have no effect until that point.
- R7: During reset, every strobe is high (all periods equal 1), and `pll1_bypass` and `pll2_bypass` read 1. This continues until the first configuration load.
- R8: `pll1_bypass` is the inverse of `cfg_core[23]`, updated under the same rule as R6. `pll2_bypass` is the inverse of `cfg_usb[19]`, updated at the edge ending a cycle with `usb_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main PLL clock |
| rst | input | 1 | Synchronous active-high reset, `clk` domain |
| cfg_core | input | 32 | Core clock configuration word |
| usb_clk | input | 1 | USB PLL clock |
| usb_rst | input | 1 | Synchronous active-high reset, `usb_clk` domain |
| cfg_usb | input | 32 | USB clock configuration word |
| fclk_en | output | 1 | Processor clock enable strobe |
| hclk_en | output | 1 | Bus clock enable strobe |
| pclk_en | output | 1 | Peripheral clock enable strobe |
| pll1_bypass | output | 1 | Main PLL bypass status |
| usb_en | output | 1 | USB host clock enable strobe |
| pll2_bypass | output | 1 | USB PLL bypass status |

## Verification
The bench builds the block with its default field positions and counter widths. These reach the largest divisors the tables hold: 16 for the processor, 32 for the bus, 8 times 32 (256) for the peripheral and 16 for the USB strobe.

Every core code is covered, including the three reserved processor codes and both non-power-of-two bus divisors. Pulses are counted over a window that is a whole multiple of every possible period. A directed test changes the configuration right after a common boundary. It shows the old 256-cycle pattern running to completion before the new divisors take over.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

    localparam int CFG_W      = 32;

    // configuration field positions
    localparam int F_LSB      = 25;
    localparam int H_LSB      = 20;
    localparam int P_LSB      = 18;
    localparam int U_LSB      = 28;
    localparam int PLL1_RUN   = 23;
    localparam int PLL2_RUN   = 19;

    localparam int F_CODE_W   = 3;
    localparam int H_CODE_W   = 3;
    localparam int P_CODE_W   = 2;
    localparam int U_CODE_W   = 4;

    // counter widths hold (divisor - 1)
    localparam int FCNT_W     = 4;
    localparam int HCNT_W     = 5;
    localparam int PCNT_W     = 3;
    localparam int UCNT_W     = U_CODE_W;

    localparam logic [CFG_W-1:0] CORE_USED =
        ({{(CFG_W-F_CODE_W){1'b0}}, {F_CODE_W{1'b1}}} << F_LSB) |
        ({{(CFG_W-H_CODE_W){1'b0}}, {H_CODE_W{1'b1}}} << H_LSB) |
        ({{(CFG_W-P_CODE_W){1'b0}}, {P_CODE_W{1'b1}}} << P_LSB) |
        ({{(CFG_W-1){1'b0}}, 1'b1} << PLL1_RUN);

    localparam logic [CFG_W-1:0] USB_USED =
        ({{(CFG_W-U_CODE_W){1'b0}}, {U_CODE_W{1'b1}}} << U_LSB) |
        ({{(CFG_W-1){1'b0}}, 1'b1} << PLL2_RUN);

    typedef struct packed {
        logic [FCNT_W-1:0] f_last;
        logic [HCNT_W-1:0] h_last;
        logic [PCNT_W-1:0] p_last;
        logic              bypass;
    } core_div_t;

    localparam core_div_t CORE_RST = '{f_last: '0, h_last: '0, p_last: '0, bypass: 1'b1};

    function automatic logic [FCNT_W-1:0] f_last_of(input logic [F_CODE_W-1:0] code);
        case (code)
            3'd1:    return FCNT_W'(1);
            3'd2:    return FCNT_W'(3);
            3'd3:    return FCNT_W'(7);
            3'd4:    return FCNT_W'(15);
            default: return '0;
        endcase
    endfunction

    function automatic logic [HCNT_W-1:0] h_last_of(input logic [H_CODE_W-1:0] code);
        case (code)
            3'd0:    return HCNT_W'(0);
            3'd1:    return HCNT_W'(1);
            3'd2:    return HCNT_W'(3);
            3'd3:    return HCNT_W'(4);
            3'd4:    return HCNT_W'(5);
            3'd5:    return HCNT_W'(7);
            3'd6:    return HCNT_W'(15);
            default: return HCNT_W'(31);
        endcase
    endfunction

    function automatic logic [PCNT_W-1:0] p_last_of(input logic [P_CODE_W-1:0] code);
        return PCNT_W'((1 << code) - 1);
    endfunction

    function automatic core_div_t decode_core(input logic [F_CODE_W-1:0] fc,
                                              input logic [H_CODE_W-1:0] hc,
                                              input logic [P_CODE_W-1:0] pc,
                                              input logic                run);
        core_div_t d;
        d.f_last = f_last_of(fc);
        d.h_last = h_last_of(hc);
        d.p_last = p_last_of(pc);
        d.bypass = ~run;
        return d;
    endfunction

endpackage

// File: rtl/bclk_cnt.sv
module bclk_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         restart,
    input  logic [W-1:0] last,
    output logic         term
);
    logic [W-1:0] cnt;

    assign term = (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (adv)
            cnt <= term ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/bclk_core_div.sv
module bclk_core_div
    import bclk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [F_CODE_W-1:0] f_code,
    input  logic [H_CODE_W-1:0] h_code,
    input  logic [P_CODE_W-1:0] p_code,
    input  logic                pll_run,
    output logic                fclk_en,
    output logic                hclk_en,
    output logic                pclk_en,
    output logic                bypass
);
    core_div_t cur;
    logic f_term, h_term, p_term, boundary;

    assign boundary = f_term && h_term && p_term;

    bclk_cnt #(.W(FCNT_W)) u_fcnt (
        .clk(clk), .rst(rst), .adv(1'b1), .restart(boundary),
        .last(cur.f_last), .term(f_term));

    bclk_cnt #(.W(HCNT_W)) u_hcnt (
        .clk(clk), .rst(rst), .adv(1'b1), .restart(boundary),
        .last(cur.h_last), .term(h_term));

    // peripheral counter steps once per bus strobe
    bclk_cnt #(.W(PCNT_W)) u_pcnt (
        .clk(clk), .rst(rst), .adv(h_term), .restart(boundary),
        .last(cur.p_last), .term(p_term));

    always_ff @(posedge clk) begin
        if (rst)
            cur <= CORE_RST;
        else if (boundary)
            cur <= decode_core(f_code, h_code, p_code, pll_run);
    end

    assign fclk_en = f_term;
    assign hclk_en = h_term;
    assign pclk_en = h_term && p_term;
    assign bypass  = cur.bypass;
endmodule

// File: rtl/bclk_usb_div.sv
module bclk_usb_div
    import bclk_pkg::*;
(
    input  logic                usb_clk,
    input  logic                usb_rst,
    input  logic [U_CODE_W-1:0] u_code,
    input  logic                pll_run,
    output logic                usb_en,
    output logic                bypass
);
    logic [UCNT_W-1:0] u_last;
    logic              u_term;
    logic              byp_q;

    bclk_cnt #(.W(UCNT_W)) u_ucnt (
        .clk(usb_clk), .rst(usb_rst), .adv(1'b1), .restart(1'b0),
        .last(u_last), .term(u_term));

    always_ff @(posedge usb_clk) begin
        if (usb_rst) begin
            u_last <= '0;
            byp_q  <= 1'b1;
        end else if (u_term) begin
            u_last <= u_code;
            byp_q  <= ~pll_run;
        end
    end

    assign usb_en = u_term;
    assign bypass = byp_q;
endmodule

// File: rtl/bus_clk_en_gen.sv
module bus_clk_en_gen
    import bclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_core,
    input  logic             usb_clk,
    input  logic             usb_rst,
    input  logic [CFG_W-1:0] cfg_usb,
    output logic             fclk_en,
    output logic             hclk_en,
    output logic             pclk_en,
    output logic             pll1_bypass,
    output logic             usb_en,
    output logic             pll2_bypass
);
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^(cfg_core & ~CORE_USED) ^ ^(cfg_usb & ~USB_USED);

    bclk_core_div u_core (
        .clk     (clk),
        .rst     (rst),
        .f_code  (cfg_core[F_LSB +: F_CODE_W]),
        .h_code  (cfg_core[H_LSB +: H_CODE_W]),
        .p_code  (cfg_core[P_LSB +: P_CODE_W]),
        .pll_run (cfg_core[PLL1_RUN]),
        .fclk_en (fclk_en),
        .hclk_en (hclk_en),
        .pclk_en (pclk_en),
        .bypass  (pll1_bypass)
    );

    bclk_usb_div u_usb (
        .usb_clk (usb_clk),
        .usb_rst (usb_rst),
        .u_code  (cfg_usb[U_LSB +: U_CODE_W]),
        .pll_run (cfg_usb[PLL2_RUN]),
        .usb_en  (usb_en),
        .bypass  (pll2_bypass)
    );
endmodule

// File: rtl/bus_clk_en_chk.sv
module bus_clk_en_chk (
    input logic clk,
    input logic rst,
    input logic usb_clk,
    input logic usb_rst,
    input logic fclk_en,
    input logic hclk_en,
    input logic pclk_en,
    input logic pll1_bypass,
    input logic usb_en,
    input logic pll2_bypass
);
    localparam int GAP_W = 7;
    localparam int F_MAX = 16;
    localparam int H_MAX = 32;

    logic [GAP_W-1:0] fgap, hgap;

    always_ff @(posedge clk) begin
        if (rst) begin
            fgap <= '0;
            hgap <= '0;
        end else begin
            fgap <= fclk_en ? '0 : fgap + 1'b1;
            hgap <= hclk_en ? '0 : hgap + 1'b1;
        end
    end

    assert_fclk_gap_R1: assert property (@(posedge clk) disable iff (rst)
        fgap < GAP_W'(F_MAX));

    assert_hclk_gap_R2: assert property (@(posedge clk) disable iff (rst)
        hgap < GAP_W'(H_MAX));

    assert_pclk_on_hclk_R3: assert property (@(posedge clk) disable iff (rst)
        pclk_en |-> hclk_en);

    assert_reset_div1_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fclk_en && hclk_en && pclk_en && pll1_bypass));

    assert_load_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(pll1_bypass) |-> $past(fclk_en && hclk_en && pclk_en));

    assert_usb_load_R8: assert property (@(posedge usb_clk) disable iff (usb_rst)
        !$stable(pll2_bypass) |-> $past(usb_en));
endmodule

bind bus_clk_en_gen bus_clk_en_chk u_chk (
    .clk(clk), .rst(rst), .usb_clk(usb_clk), .usb_rst(usb_rst),
    .fclk_en(fclk_en), .hclk_en(hclk_en), .pclk_en(pclk_en),
    .pll1_bypass(pll1_bypass), .usb_en(usb_en), .pll2_bypass(pll2_bypass));

// File: tb/bus_clk_en_gen_test.sv
`timescale 1ns/100ps
module bus_clk_en_gen_test;

    logic        clk = 1'b0, usb_clk = 1'b0;
    logic        rst = 1'b1, usb_rst = 1'b1;
    logic [31:0] cfg_core = '0, cfg_usb = '0;
    logic        fclk_en, hclk_en, pclk_en, pll1_bypass, usb_en, pll2_bypass;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;
    always #5 usb_clk = ~usb_clk;

    bus_clk_en_gen uut (
        .clk(clk), .rst(rst), .cfg_core(cfg_core),
        .usb_clk(usb_clk), .usb_rst(usb_rst), .cfg_usb(cfg_usb),
        .fclk_en(fclk_en), .hclk_en(hclk_en), .pclk_en(pclk_en),
        .pll1_bypass(pll1_bypass), .usb_en(usb_en), .pll2_bypass(pll2_bypass));

    localparam int WIN  = 3840;   // multiple of every core period
    localparam int UWIN = 720;    // multiple of every tested USB period

    // {f_code, h_code, p_code, f_period, h_period, p_period}
    localparam logic [28:0] VEC [8] = '{
        {3'd0, 3'd0, 2'd0, 6'd1,  6'd1,  9'd1},
        {3'd1, 3'd1, 2'd1, 6'd2,  6'd2,  9'd4},
        {3'd2, 3'd3, 2'd2, 6'd4,  6'd5,  9'd20},
        {3'd3, 3'd4, 2'd3, 6'd8,  6'd6,  9'd48},
        {3'd4, 3'd7, 2'd3, 6'd16, 6'd32, 9'd256},
        {3'd5, 3'd2, 2'd0, 6'd1,  6'd4,  9'd4},
        {3'd6, 3'd5, 2'd1, 6'd1,  6'd8,  9'd16},
        {3'd7, 3'd6, 2'd2, 6'd1,  6'd16, 9'd64}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_core(input logic [2:0] f, input logic [2:0] h,
                                            input logic [1:0] p, input logic run);
        logic [31:0] w;
        w = 32'h0002_A5A5;          // noise in unused bits
        w[27:25] = f;
        w[23]    = run;
        w[22:20] = h;
        w[19:18] = p;
        return w;
    endfunction

    function automatic logic [31:0] mk_usb(input logic [3:0] u, input logic run);
        logic [31:0] w;
        w = 32'h0005_3C3C;
        w[31:28] = u;
        w[19]    = run;
        return w;
    endfunction

    task automatic count_core(output int nf, output int nh, output int np);
        nf = 0; nh = 0; np = 0;
        repeat (WIN) begin
            @(negedge clk);
            nf += int'(fclk_en);
            nh += int'(hclk_en);
            np += int'(pclk_en);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int nf, nh, np, nu, ncount;
        cfg_core = mk_core(3'd2, 3'd3, 2'd1, 1'b1);
        cfg_usb  = mk_usb(4'd3, 1'b1);
        repeat (3) @(negedge clk);

        // R7: reset state
        check("R7 fclk_en in reset", int'(fclk_en), 1);
        check("R7 hclk_en in reset", int'(hclk_en), 1);
        check("R7 pclk_en in reset", int'(pclk_en), 1);
        check("R7 pll1_bypass in reset", int'(pll1_bypass), 1);
        check("R7 pll2_bypass in reset", int'(pll2_bypass), 1);
        @(negedge usb_clk);
        check("R7 usb_en in reset", int'(usb_en), 1);
        usb_rst = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // R1 R2 R3 R5 R8: table walk
        for (int i = 0; i < 8; i++) begin
            cfg_core = mk_core(VEC[i][28:26], VEC[i][25:23], VEC[i][22:21], i[0]);
            repeat (300) @(negedge clk);
            count_core(nf, nh, np);
            check($sformatf("R1 R5 fclk count vec %0d", i), nf, WIN / int'(VEC[i][20:15]));
            check($sformatf("R2 R5 hclk count vec %0d", i), nh, WIN / int'(VEC[i][14:9]));
            check($sformatf("R3 pclk count vec %0d", i), np, WIN / int'(VEC[i][8:0]));
            check($sformatf("R8 pll1_bypass vec %0d", i), int'(pll1_bypass), int'(!i[0]));
        end

        // R6: change just after a common boundary is held off
        cfg_core = mk_core(3'd4, 3'd7, 2'd3, 1'b1);
        repeat (300) @(negedge clk);
        while (!(fclk_en && hclk_en && pclk_en)) @(negedge clk);
        @(negedge clk);
        cfg_core = mk_core(3'd0, 3'd0, 2'd0, 1'b0);
        ncount = 0;
        repeat (254) begin
            @(negedge clk);
            ncount += int'(hclk_en);
        end
        check("R6 old hclk pulses before boundary", ncount, 7);
        check("R6 R8 bypass held before boundary", int'(pll1_bypass), 0);
        @(negedge clk);
        check("R6 boundary all strobes", int'(fclk_en && hclk_en && pclk_en), 1);
        @(negedge clk);
        check("R6 R8 bypass after boundary", int'(pll1_bypass), 1);
        check("R6 new div1 hclk", int'(hclk_en), 1);
        @(negedge clk);
        check("R6 R5 div1 continuous", int'(fclk_en && hclk_en && pclk_en), 1);

        // R4 R8: USB divider
        for (int k = 0; k < 3; k++) begin
            logic [3:0] code;
            code = (k == 0) ? 4'd0 : (k == 1) ? 4'd4 : 4'd15;
            cfg_usb = mk_usb(code, k[0]);
            repeat (40) @(negedge usb_clk);
            nu = 0;
            repeat (UWIN) begin
                @(negedge usb_clk);
                nu += int'(usb_en);
            end
            check($sformatf("R4 usb count code %0d", code), nu, UWIN / (int'(code) + 1));
            check($sformatf("R8 pll2_bypass code %0d", code), int'(pll2_bypass), int'(!k[0]));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule